// File: doc/BRIEF.md
# Watchdog Timer with Oscillator-Settling Delay

This block is an 8-bit up-counter with a clock prescaler. Software reaches it through two byte-wide registers on a simple write/read bus: a control/status register and the counter itself. It has three uses. In watchdog mode it raises a reset pulse, of a selectable kind, when software stops clearing the counter. In interval mode it raises an interrupt pulse on every overflow and keeps counting.

Its third use is as a settling-delay timer for the clock controller. When standby is left or the clock frequency is changed, the controller pulses `settle_start`. The counter then runs from the value software preloaded, whether or not the timer is enabled. On overflow the block issues a one-cycle `restart_req` and neither status flag changes. The counter then stays at 0x00. Software can read it back to confirm the delay is complete before it rewrites the counter.

Every write must carry a key in the upper byte of the 16-bit write data. A write without the right key is dropped, so runaway code cannot easily disable or reload the timer.

Top module: `wdt_settle_timer`

## Requirements
- R1: After reset the control/status register reads 0x00, the counter reads 0x00, and `irq`, `wdt_rst` and `restart_req` are low.
- R2: A write to the control/status register (`bus_addr`=0) takes effect only when `bus_wdata[15:8]` is 0xA5. A write to the counter (`bus_addr`=1) takes effect only when `bus_wdata[15:8]` is 0x5A. Any other write leaves the register unchanged.
- R3: The control/status register has this layout: bit 7 is enable, bit 6 is mode (1 = watchdog, 0 = interval), bit 5 is reset kind, bit 4 is the watchdog-overflow flag, bit 3 is the interval-overflow flag, and bits 2:0 are the clock select. Reads through `bus_rdata` return the register selected by `bus_addr`.
- R4: With clock select s, the counter advances once every 2^(PRE_BASE+s) clock cycles. Suppose the counter is preloaded with v and the enable is then set by a write at clock edge E. The first overflow pulse then appears after edge E + (256-v)·2^(PRE_BASE+s).
- R5: In interval mode an overflow gives a one-cycle `irq` and sets the interval flag. The counter wraps to 0x00 and keeps counting, so the next overflow follows 256·2^(PRE_BASE+s) cycles later.
- R6: In watchdog mode an overflow gives a one-cycle `wdt_rst`, sets the watchdog flag and gives no `irq`. `wdt_rst_kind` equals the reset-kind bit.
- R7: Writing 0x00 to the counter more often than the overflow period prevents any `wdt_rst`.
- R8: A status flag is cleared by writing 0 to its bit. Writing 1 to its bit leaves it unchanged.
- R9: A `settle_start` pulse starts counting from the preloaded value even when enable is 0, with the same timing as R4. The overflow gives a single-cycle `restart_req`.
- R10: An overflow that ends a settling delay sets neither flag and raises neither `irq` nor `wdt_rst`.
- R11: After the settling overflow the counter holds at 0x00, even if enable is then set. Only a keyed counter write releases it, after which normal counting resumes with the R4 timing.
- R12: With enable at 0 and no settling delay running, the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 = control/status, 1 = counter |
| bus_wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_rdata | output | 8 | Read data of the selected register |
| settle_start | input | 1 | Pulse from the clock controller that starts a settling delay |
| restart_req | output | 1 | One-cycle clock-restart request at the end of the delay |
| irq | output | 1 | One-cycle interval-overflow interrupt |
| wdt_rst | output | 1 | One-cycle watchdog reset request |
| wdt_rst_kind | output | 1 | Reset kind chosen for `wdt_rst` |

## Verification
The count clock is swept over all eight select values with a short preload, measuring the cycle at which the first overflow appears. This separates a wrong divide ratio from an off-by-one in the prescaler or counter start. Interval mode is also run through a full wrap, so that a counter which stops or reloads after overflow can be told apart from one that wraps. Watchdog overflows are tried with both reset kinds, and periodic servicing shows that no reset appears. Settling delays are run with the enable cleared and then set, which separates the restart path from the flag and interrupt paths and shows that the counter holds at zero. Unkeyed writes, flag writes of 1 and of 0, and an idle disabled counter check that each register holds its state.

// File: rtl/wst_pkg.sv
package wst_pkg;
  typedef struct packed {
    logic       en;
    logic       wdt_mode;
    logic       rst_kind;
    logic       wovf;
    logic       iovf;
    logic [2:0] cks;
  } csr_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HALT   = 2'd2
  } settle_e;
endpackage

// File: rtl/wst_prescaler.sv
module wst_prescaler #(
  parameter int PRE_BASE = 5,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL = 1 << SEL_W;
  localparam int PW   = PRE_BASE + NSEL - 1;

  logic [PW-1:0]   presc_q, presc_d;
  logic [NSEL-1:0] tick_vec;

  always_comb begin
    presc_d = presc_q;
    if (!run) presc_d = '0;
    else      presc_d = presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    assign tick_vec[g] = &presc_q[PRE_BASE+g-1:0];
  end

  assign tick = run && tick_vec[sel];

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(run)); // R12
endmodule

// File: rtl/wst_ctrl.sv
module wst_ctrl import wst_pkg::*; #(
  parameter logic [7:0] KEY_CSR = 8'hA5,
  parameter logic [7:0] KEY_CNT = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        ovf_evt,
  output csr_t        csr,
  output logic        cnt_wr,
  output logic [7:0]  cnt_wdata,
  output logic        irq,
  output logic        wdt_rst
);
  csr_t csr_q, csr_d;
  logic irq_q, irq_d, rst_q, rst_d;
  logic csr_wr;
  csr_t wr_val;

  assign csr_wr    = bus_wr && !bus_addr && (bus_wdata[15:8] == KEY_CSR);
  assign cnt_wr    = bus_wr &&  bus_addr && (bus_wdata[15:8] == KEY_CNT);
  assign cnt_wdata = bus_wdata[7:0];
  assign wr_val    = csr_t'(bus_wdata[7:0]);

  always_comb begin
    csr_d = csr_q;
    if (csr_wr) begin
      csr_d.en       = wr_val.en;
      csr_d.wdt_mode = wr_val.wdt_mode;
      csr_d.rst_kind = wr_val.rst_kind;
      csr_d.cks      = wr_val.cks;
      csr_d.wovf     = csr_q.wovf & wr_val.wovf;
      csr_d.iovf     = csr_q.iovf & wr_val.iovf;
    end
    if (ovf_evt &&  csr_q.wdt_mode) csr_d.wovf = 1'b1;
    if (ovf_evt && !csr_q.wdt_mode) csr_d.iovf = 1'b1;
    irq_d = ovf_evt && !csr_q.wdt_mode;
    rst_d = ovf_evt &&  csr_q.wdt_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= '0;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      csr_q <= csr_d;
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end

  assign csr     = csr_q;
  assign irq     = irq_q;
  assign wdt_rst = rst_q;

  AST_WOVF_FROM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_q.wovf) |-> $past(ovf_evt)); // R10
  AST_IOVF_FROM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_q.iovf) |-> $past(ovf_evt)); // R10
  AST_IRQ_RST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_q && rst_q)); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R5
endmodule

// File: rtl/wst_counter.sv
module wst_counter import wst_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             settle_start,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             ovf_evt,
  output logic             restart_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  settle_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rs_q, rs_d;
  logic             wrap;

  assign wrap = tick && (cnt_q == CNT_MAX);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:   if (settle_start)     st_d = ST_SETTLE;
      ST_SETTLE: if (!cnt_wr && wrap)  st_d = ST_HALT;
      ST_HALT:   if (cnt_wr)           st_d = ST_IDLE;
      default:                         st_d = ST_IDLE;
    endcase
    if (cnt_wr)    cnt_d = cnt_wdata;
    else if (tick) cnt_d = cnt_q + 1'b1;
    rs_d = wrap && !cnt_wr && (st_q == ST_SETTLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rs_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rs_q  <= rs_d;
    end
  end

  assign run         = ((st_q == ST_IDLE) && en) || (st_q == ST_SETTLE);
  assign ovf_evt     = wrap && !cnt_wr && (st_q == ST_IDLE);
  assign cnt         = cnt_q;
  assign restart_req = rs_q;

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT) && !cnt_wr |=> $stable(cnt_q)); // R11
  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rs_q |-> (cnt_q == '0) && (st_q == ST_HALT)); // R11
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rs_q |=> !rs_q); // R9
  AST_NO_OVF_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> !ovf_evt); // R10
endmodule

// File: rtl/wdt_settle_timer.sv
module wdt_settle_timer import wst_pkg::*; #(
  parameter int         PRE_BASE = 5,
  parameter logic [7:0] KEY_CSR  = 8'hA5,
  parameter logic [7:0] KEY_CNT  = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        settle_start,
  output logic        restart_req,
  output logic        irq,
  output logic        wdt_rst,
  output logic        wdt_rst_kind
);
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;

  csr_t             csr;
  logic             cnt_wr;
  logic [CNT_W-1:0] cnt_wdata, cnt;
  logic             ovf_evt, run, tick;

  wst_ctrl #(.KEY_CSR(KEY_CSR), .KEY_CNT(KEY_CNT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ovf_evt   (ovf_evt),
    .csr       (csr),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .irq       (irq),
    .wdt_rst   (wdt_rst)
  );

  wst_prescaler #(.PRE_BASE(PRE_BASE), .SEL_W(SEL_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (csr.cks),
    .tick  (tick)
  );

  wst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (csr.en),
    .tick         (tick),
    .cnt_wr       (cnt_wr),
    .cnt_wdata    (cnt_wdata),
    .settle_start (settle_start),
    .cnt          (cnt),
    .run          (run),
    .ovf_evt      (ovf_evt),
    .restart_req  (restart_req)
  );

  assign bus_rdata    = bus_addr ? cnt : csr;
  assign wdt_rst_kind = csr.rst_kind;
endmodule

// File: tb/wdt_settle_timer_bench.sv
module wdt_settle_timer_bench;
  localparam int PB = 1;

  logic        clk, rst_n, bus_wr, bus_addr, settle_start;
  logic [15:0] bus_wdata;
  logic [7:0]  bus_rdata;
  logic        restart_req, irq, wdt_rst, wdt_rst_kind;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  wdt_settle_timer #(.PRE_BASE(PB)) u_wdt_settle_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .settle_start(settle_start),
    .restart_req(restart_req), .irq(irq), .wdt_rst(wdt_rst),
    .wdt_rst_kind(wdt_rst_kind));

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] key, input logic [7:0] val);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = {key, val};
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  // Waits for a pulse; returns edges counted since the last write edge
  // and the number of cycles irq/wdt_rst/restart were seen high.
  task automatic wait_pulse(input int which, input int limit, output int k,
                            output int side);
    bit seen = 0;
    k = 0; side = 0;
    while (!seen && k < limit) begin
      @(negedge clk);
      k++;
      if ((which == 0 && irq) || (which == 1 && wdt_rst) ||
          (which == 2 && restart_req)) seen = 1;
      else if (irq || wdt_rst || restart_req) side++;
    end
    if (!seen) k = -1;
  endtask

  initial begin
    int v, k, side;
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = '0; settle_start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, v); chk("R1 csr", v, 0);
    rd(1, v); chk("R1 cnt", v, 0);
    chk("R1 outs", {irq, wdt_rst, restart_req}, 0);

    // R2 unkeyed writes ignored, keyed ones taken
    wr(0, 8'h00, 8'hC7); rd(0, v); chk("R2 csr nokey", v, 0);
    wr(1, 8'hA5, 8'h33); rd(1, v); chk("R2 cnt wrongkey", v, 0);
    wr(1, 8'h5A, 8'h10); rd(1, v); chk("R2 cnt key", v, 8'h10);
    wr(0, 8'h5A, 8'h80); rd(0, v); chk("R2 csr wrongkey", v, 0);
    wr(0, 8'hA5, 8'h65); rd(0, v); chk("R3 csr fields", v, 8'h65);

    // R12 disabled counter holds
    wr(0, 8'hA5, 8'h00);
    repeat (100) @(negedge clk);
    rd(1, v); chk("R12 hold", v, 8'h10);

    // R4/R5 sweep every clock select in interval mode
    for (int s = 0; s < 8; s++) begin
      wr(0, 8'hA5, 8'h00);
      wr(1, 8'h5A, 8'd252);
      wr(0, 8'hA5, 8'h80 | s[7:0]);
      wait_pulse(0, 5000, k, side);
      chk($sformatf("R4 period sel%0d", s), k, 4 * (1 << (PB + s)));
      @(negedge clk);
      chk("R5 irq width", irq, 0);
      rd(0, v); chk("R5 iovf set", v & 8'h08, 8'h08);
      if (s == 0) begin
        // next overflow after a full wrap; two edges used since the pulse
        wait_pulse(0, 5000, k, side);
        chk("R5 wrap period", k + 2, 256 * (1 << PB));
      end
    end

    // R8 flag write-1 keeps, write-0 clears
    wr(0, 8'hA5, 8'h08); rd(0, v); chk("R8 keep", v, 8'h08);
    wr(0, 8'hA5, 8'h00); rd(0, v); chk("R8 clear", v, 0);

    // R6 watchdog overflow with both reset kinds
    for (int rk = 0; rk < 2; rk++) begin
      wr(0, 8'hA5, 8'h00);
      wr(1, 8'h5A, 8'hF8);
      wr(0, 8'hA5, 8'hC0 | (rk[7:0] << 5));
      wait_pulse(1, 5000, k, side);
      chk("R6 wdt period", k, 8 * (1 << PB));
      chk("R6 kind", wdt_rst_kind, rk);
      chk("R6 no irq", side, 0);
      rd(0, v); chk("R6 wovf", v & 8'h18, 8'h10);
    end

    // R7 servicing prevents reset
    wr(0, 8'hA5, 8'h00);
    wr(1, 8'h5A, 8'h00);
    wr(0, 8'hA5, 8'hC0);
    side = 0;
    for (int i = 0; i < 20; i++) begin
      repeat (100) begin
        @(negedge clk);
        if (wdt_rst) side++;
      end
      wr(1, 8'h5A, 8'h00);
    end
    chk("R7 serviced", side, 0);

    // R9/R10/R11 settling delay with enable cleared
    wr(0, 8'hA5, 8'h00);
    wr(1, 8'h5A, 8'hF0);
    wr(0, 8'hA5, 8'h01);
    @(negedge clk); settle_start = 1;
    @(negedge clk); settle_start = 0;
    wait_pulse(2, 5000, k, side);
    chk("R9 settle delay", k, 16 * (1 << (PB + 1)));
    chk("R10 no irq/rst", side, 0);
    @(negedge clk);
    chk("R9 restart width", restart_req, 0);
    rd(0, v); chk("R10 flags", v & 8'h18, 0);
    rd(1, v); chk("R11 stop zero", v, 0);
    wr(0, 8'hA5, 8'h81);
    repeat (200) @(negedge clk);
    rd(1, v); chk("R11 halt hold", v, 0);
    chk("R10 no irq halt", irq, 0);
    wr(1, 8'h5A, 8'hFE);
    wait_pulse(0, 5000, k, side);
    chk("R11 resume", k, 2 * (1 << (PB + 1)));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule